// File: doc/BRIEF.md
# Asynchronous EPROM Word-Read Controller

This block sits between a synchronous host and an asynchronous, read-only parallel memory with an 18-bit address bus and a 16-bit data bus. On a host read request it drives the address, pulls chip enable low, and pulls output enable low later. It waits the programmed number of clock cycles for each access budget, captures the word, and then releases the bus. All three access budgets (from address, from chip enable and from output enable) and the bus-release time are given in nanoseconds. Each is converted to whole clock cycles from the clock period parameter.

An identifier request runs two back-to-back accesses. During both, a high-voltage select output is raised for address line 9 and every other address line except bit 0 is held low. The first access has bit 0 low and returns the manufacturer byte. The second has bit 0 high and returns the device byte. The two low data bytes are then returned together as a single 16-bit result.

The controller is a three-state machine with the states `ST_IDLE`, `ST_ACCESS` and `ST_RELEASE`:
- `ST_IDLE` moves to `ST_ACCESS` when a request is present.
- `ST_ACCESS` moves to `ST_RELEASE` after the access window ends.
- `ST_RELEASE` moves to `ST_IDLE` once the release time is done. For the first half of an identifier read it moves back to `ST_ACCESS` instead.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held and directly after it, chip enable and output enable are high, the high-voltage select is low, `rd_valid` is low and `req_ready` is high.
- R2: Output enable is never low unless chip enable is also low. Outside an access, both enables are high, so the memory's outputs stay in high impedance.
- R3: The address on `mem_addr` does not change while chip enable remains low.
- R4: Timing of an access, where ACC = the largest of ceil(T_ADDR_NS/CLK_NS), ceil(T_CE_NS/CLK_NS) and ceil(T_OE_NS/CLK_NS):
  - Chip enable is low for exactly ACC cycles.
  - Output enable is low for the last ceil(T_OE_NS/CLK_NS) of those cycles.
  - The data bus is sampled at the clock edge that ends the window.
  - For a normal read, `rd_valid` rises ACC+1 clock cycles after the cycle in which the request was driven.
- R5: `rd_valid` is a single-cycle pulse. For a normal read, `rd_data` then equals the word stored at the requested address.
- R6: After each capture, both enables stay high for at least ceil(T_DIS_NS/CLK_NS) cycles before chip enable falls again, and `req_ready` stays low during that time.
- R7: For an identifier request:
  - `mem_hv_a9` is high during both accesses.
  - `mem_addr[17:1]` is zero.
  - The first access uses `mem_addr[0]`=0 and the second uses 1.
  - `rd_data` = {byte read with bit 0 low, byte read with bit 0 high}, which is 16'h9730 for a conforming memory.
  - `rd_valid` rises 2*ACC+DIS+1 cycles after the request.
- R8: Requests presented while `req_ready` is low are ignored. They start no access and produce no extra `rd_valid`.
- R9: If `rd_req` and `id_req` are both high in the same accepted cycle, the identifier read is performed.
- R10: `mem_hv_a9` is low throughout every normal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Word-read request, taken when `req_ready` is high |
| id_req | input | 1 | Identifier-read request, taken when `req_ready` is high; wins over `rd_req` |
| rd_addr | input | 18 | Word address for a read request |
| req_ready | output | 1 | High when a request can be accepted |
| rd_data | output | 16 | Captured word, or {manufacturer byte, device byte} for an identifier read |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` as valid |
| mem_addr | output | 18 | Address lines to the memory |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_hv_a9 | output | 1 | Selects the high-voltage source for address line 9 |
| mem_dq | input | 16 | Data lines from the memory |

## Verification
The in-RTL assertions check the following on every cycle:
- the enable ordering;
- that the address holds during an access;
- that `rd_valid` is a single-cycle pulse;
- that the release gap has a minimum length;
- that only bit 0 can be set on the address while the high-voltage select is raised.

Other behaviours can only be shown by the bench's scenarios, because they depend on what the memory returns. The bench uses a memory model that drives X until each access budget has run out. Against this model it shows that the data is sampled no earlier than the longest budget allows, that the latency is exact, that the two identifier bytes are assembled in the right order, and that requests made while busy are ignored.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RELEASE = 2'd2
    } rd_state_t;

    // nanoseconds to whole clock cycles, never less than one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != {CW{1'b1}})
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic          id_mode,
    input  logic          id_first,
    input  logic [DW-1:0] dq,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [7:0] first_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_byte <= '0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (sample) begin
                if (id_mode && id_first) begin
                    first_byte <= dq[7:0];
                end else begin
                    rd_valid <= 1'b1;
                    if (id_mode)
                        rd_data <= {{(DW-16){1'b0}}, first_byte, dq[7:0]};
                    else
                        rd_data <= dq;
                end
            end
        end
    end

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl #(
    parameter int AW        = 18,
    parameter int DW        = 16,
    parameter int CLK_NS    = 10,
    parameter int T_ADDR_NS = 100,
    parameter int T_CE_NS   = 100,
    parameter int T_OE_NS   = 50,
    parameter int T_DIS_NS  = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          id_req,
    input  logic [AW-1:0] rd_addr,
    output logic          req_ready,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_hv_a9,
    input  logic [DW-1:0] mem_dq
);
    import eprom_rd_pkg::*;

    localparam int ADDR_CYC = ns_to_cyc(T_ADDR_NS, CLK_NS);
    localparam int CE_CYC   = ns_to_cyc(T_CE_NS, CLK_NS);
    localparam int OE_CYC   = ns_to_cyc(T_OE_NS, CLK_NS);
    localparam int DIS_CYC  = ns_to_cyc(T_DIS_NS, CLK_NS);
    localparam int ACC_CYC  = max2(max2(ADDR_CYC, CE_CYC), OE_CYC);
    localparam int OE_START = ACC_CYC - OE_CYC;
    localparam int CW       = $clog2(max2(ACC_CYC, DIS_CYC) + 2);

    rd_state_t     state, state_nx;
    logic [CW-1:0] cnt;
    logic          is_id, phase;
    logic [AW-1:0] addr_q;
    logic          acc_end, rel_end, take;

    assign acc_end = (state == ST_ACCESS)  && (cnt == CW'(ACC_CYC - 1));
    assign rel_end = (state == ST_RELEASE) && (cnt == CW'(DIS_CYC - 1));
    assign take    = (state == ST_IDLE) && (rd_req || id_req);

    eprom_rd_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_nx != state),
        .cnt   (cnt)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (take) state_nx = ST_ACCESS;
            ST_ACCESS:  if (acc_end) state_nx = ST_RELEASE;
            ST_RELEASE: if (rel_end) state_nx = (is_id && !phase) ? ST_ACCESS : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_id  <= 1'b0;
            phase  <= 1'b0;
            addr_q <= '0;
        end else if (take) begin
            is_id  <= id_req;
            phase  <= 1'b0;
            addr_q <= id_req ? '0 : rd_addr;
        end else if (rel_end && is_id && !phase) begin
            phase     <= 1'b1;
            addr_q[0] <= 1'b1;
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_addr  = addr_q;
        mem_ce_n  = (state != ST_ACCESS);
        mem_oe_n  = !((state == ST_ACCESS) && (cnt >= CW'(OE_START)));
        mem_hv_a9 = is_id && (state != ST_IDLE);
    end

    eprom_rd_capture #(.DW(DW)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (acc_end),
        .id_mode  (is_id),
        .id_first (!phase),
        .dq       (mem_dq),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    p_oe_needs_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_sample_under_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!mem_oe_n));

    p_id_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hv_a9 |-> (mem_addr[AW-1:1] == '0));

    generate
        if (DIS_CYC > 1) begin : g_gap
            p_release_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_ce_n) |=> (mem_ce_n && mem_oe_n && !req_ready));
        end
    endgenerate
endmodule

// File: tb/eprom_rd_ctrl_bench.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TA_NS = 100, TOE_NS = 50, TDIS_NS = 50;
    localparam int TA  = (TA_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int TO  = (TOE_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int TD  = (TDIS_NS + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 0, rst_n = 0;
    logic        rd_req = 0, id_req = 0;
    logic [17:0] rd_addr = '0;
    logic        req_ready, rd_valid, mem_ce_n, mem_oe_n, mem_hv_a9;
    logic [15:0] rd_data, mem_dq;
    logic [17:0] mem_addr;

    int n_chk = 0, n_fail = 0, n_valid = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eprom_rd_ctrl #(.CLK_NS(CLK_PERIOD), .T_ADDR_NS(TA_NS), .T_CE_NS(TA_NS),
                    .T_OE_NS(TOE_NS), .T_DIS_NS(TDIS_NS)) u_eprom_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .id_req(id_req), .rd_addr(rd_addr),
        .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_hv_a9(mem_hv_a9), .mem_dq(mem_dq));

    function automatic logic [15:0] mem_word(input logic [17:0] a);
        return a[15:0] ^ {a[7:0], a[15:8]} ^ {a[17:16], a[17:16], 12'hC3A};
    endfunction

    // memory model: X until every access budget has run out
    int   c_addr = 0, c_ce = 0, c_oe = 0, gap = 100;
    logic [17:0] prev_addr = '0;
    logic model_ok = 0;
    logic [15:0] model_word;
    always @(negedge clk) begin
        if (mem_addr !== prev_addr) c_addr = 1; else if (c_addr < 1000) c_addr++;
        prev_addr = mem_addr;
        if (mem_ce_n) c_ce = 0; else c_ce++;
        if (mem_oe_n) c_oe = 0; else c_oe++;
        model_ok = (c_addr >= TA) && (c_ce >= TA) && (c_oe >= TO);
    end
    always_comb begin
        if (mem_hv_a9)
            model_word = (mem_addr[17:1] == '0) ? {8'h00, mem_addr[0] ? 8'h30 : 8'h97} : 'x;
        else
            model_word = mem_word(mem_addr);
    end
    assign mem_dq = (mem_ce_n || mem_oe_n) ? 'z : (model_ok ? model_word : 'x);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: release gap (R6), no OE without CE (R2), hv during reads (R10)
    logic ce_prev = 1;
    bit   cur_id = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_oe_n && mem_ce_n) check(0, "R2 oe without ce", 1, 0);
            if (ce_prev && !mem_ce_n) check(gap >= TD, "R6 release gap", gap, TD);
            if (!mem_ce_n && !cur_id && mem_hv_a9) check(0, "R10 hv during read", 1, 0);
            if (mem_ce_n) gap++; else gap = 0;
            if (rd_valid) n_valid++;
        end
        ce_prev = mem_ce_n;
    end

    task automatic do_op(input bit rd, input bit id, input logic [17:0] a, input string tag);
        int k;
        logic [15:0] exp;
        int exp_k;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_id = id;
        rd_req = rd; id_req = id; rd_addr = a;
        @(negedge clk);
        rd_req = 0; id_req = 0;
        k = 1;
        while (!rd_valid && k < 500) begin @(negedge clk); k++; end
        exp   = id ? 16'h9730 : mem_word(a);
        exp_k = id ? 2*TA + TD + 1 : TA + 1;
        check(k == exp_k, id ? {tag, " R7 id latency"} : {tag, " R4 latency"}, k, exp_k);
        check(rd_data === exp, id ? {tag, " R7 id data"} : {tag, " R5 data"}, rd_data, exp);
        @(negedge clk);
        check(!rd_valid, "R5 valid one cycle", rd_valid, 0);
        check(!req_ready, "R6 not ready after capture", req_ready, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n && !mem_hv_a9 && !rd_valid, "R1 reset outputs",
              {mem_ce_n, mem_oe_n, mem_hv_a9, rd_valid}, 4'b1100);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && mem_ce_n && mem_oe_n, "R1 after reset", {req_ready, mem_ce_n, mem_oe_n}, 3'b111);

        do_op(1, 0, 18'h00000, "corner low");
        do_op(1, 0, 18'h3FFFF, "corner high");
        do_op(0, 1, 18'h3FFFF, "id");
        do_op(1, 1, 18'h12345, "R9 both");
        check(rd_data === 16'h9730, "R9 id wins", rd_data, 16'h9730);

        // R8: requests during busy are ignored
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        v0 = n_valid;
        cur_id = 0;
        rd_req = 1; rd_addr = 18'h0ABCD;
        @(negedge clk);
        rd_req = 0;
        repeat (2) @(negedge clk);
        rd_req = 1; id_req = 1; rd_addr = 18'h15555;
        repeat (3) @(negedge clk);
        rd_req = 0; id_req = 0;
        while (!rd_valid) @(negedge clk);
        check(rd_data === mem_word(18'h0ABCD), "R8 busy data", rd_data, mem_word(18'h0ABCD));
        repeat (TA + TD + 6) @(negedge clk);
        check(n_valid - v0 == 1, "R8 no extra access", n_valid - v0, 1);
        check(req_ready && mem_ce_n, "R8 idle after ignore", {req_ready, mem_ce_n}, 2'b11);

        for (int i = 0; i < 40; i++) begin
            logic [17:0] a;
            a = 18'($urandom);
            if ($urandom_range(0, 4) == 0) do_op(0, 1, a, "rand id");
            else                           do_op(1, 0, a, "rand read");
        end

        repeat (TD + 2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule